// File: doc/BRIEF.md
# Used Ring Completion Engine

This block hands finished requests back to a guest driver over a shared-memory virtual queue. For every finished request, a command posts an element into the used ring. The element holds the head descriptor index as its id and the total byte count as its length. It lands in the slot chosen by the device's private next-used counter, and that counter then advances. The guest does not see these elements until a separate sync command copies the counter into the ring's index field. Completions are therefore batched, and one sync publishes many of them.

After publishing, the sync fetches the available-ring flag word and decides whether the guest gets a queue interrupt. The no-interrupt bit in that word normally suppresses the interrupt. When the notify-on-empty feature has been negotiated and the queue has drained, the interrupt is raised anyway. When the interrupt is suppressed, a skipped-interrupt counter grows instead. Two more commands set or clear the no-notify hint in the used-ring flag word by reading that word, modifying it and writing it back.

All memory traffic goes through one request/ready port. A command is taken in a single cycle when the engine is idle. The engine signals completion with a one-cycle done pulse. For a sync, that pulse comes only after the index write and the flag read have both finished.

Top module: `used_ring_completer`

## Requirements
- R1: After reset, `next_used` is 0, `skip_count` is 0, `irq_pulse` and `mem_valid` are low and `cmd_ready` is high.
- R2: A put command (op code 0) issues two 32-bit writes. The first carries the id, zero-extended, at `used_base + 4 + 8*slot`. The second carries the length at the next 4 bytes. `slot` is `next_used` modulo `RING_DEPTH`, so the slot wraps for a ring depth that is not a power of two.
- R3: Each completed put raises `next_used` by exactly one. A put never writes the 16-bit index field at `used_base + 2`.
- R4: A sync command (op code 1) first writes `next_used` as a 16-bit value at `used_base + 2`. It then reads the 16-bit available flags at `avail_base`. `cmd_done` pulses only after both accesses have completed.
- R5: When bit 0 of the available flags is clear, a sync ends with a single one-cycle `irq_pulse`, in the same cycle as `cmd_done`.
- R6: When bit 0 of the available flags is set, a sync still pulses `irq_pulse` if `feat_notify_empty` and `queue_empty` are both high.
- R7: When neither condition holds, a sync produces no `irq_pulse` and `skip_count` rises by one. A sync that raises the interrupt leaves `skip_count` unchanged.
- R8: Op code 2 clears bit 0 of the 16-bit used flags at `used_base`, and op code 3 sets it. Each does this as a read followed by a write, and bits 15..1 are preserved.
- R9: A memory request holds its address, data and direction stable until `mem_ready`. `cmd_ready` stays low from acceptance until the command's done pulse, so only one command runs at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| used_base | input | AW | Byte address of the used ring (flags at +0, index at +2, elements at +4) |
| avail_base | input | AW | Byte address of the available-ring flag word |
| feat_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| queue_empty | input | 1 | Available side has no pending entries |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command taken this cycle if valid |
| cmd_op | input | 2 | 0 put, 1 sync, 2 notify enable, 3 notify disable |
| cmd_id | input | ID_W | Head descriptor index for a put |
| cmd_len | input | LEN_W | Byte count for a put |
| cmd_done | output | 1 | One-cycle pulse when a command has finished |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_write | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data (low 16 bits for narrow writes) |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| irq_pulse | output | 1 | One-cycle queue interrupt request |
| skip_count | output | CNT_W | Number of suppressed interrupts |
| next_used | output | 16 | Device next-used counter |

## Verification
The checks assume that the memory side answers every request with `mem_ready` at some point. They also assume that `mem_rdata` is only meaningful in the cycle `mem_ready` is high. Finally, they assume that `feat_notify_empty` and `queue_empty` do not change while a sync is in flight. The bench memory model serves each request after zero to two wait cycles and drives read data only together with ready. The bench issues each command only after the previous done pulse and sets the feature and empty inputs before issuing a sync.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
   typedef enum logic [1:0] {
      OP_PUT     = 2'd0,
      OP_SYNC    = 2'd1,
      OP_NTF_ON  = 2'd2,
      OP_NTF_OFF = 2'd3
   } ucr_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ELEM_ID,
      ST_ELEM_LEN,
      ST_IDX_WR,
      ST_AFLG_RD,
      ST_UFLG_RD,
      ST_UFLG_WR
   } ucr_st_e;

   localparam int unsigned HDR_BYTES  = 4;
   localparam int unsigned ELEM_SHIFT = 3;
   localparam int unsigned IDX_OFS    = 2;
   localparam int unsigned LEN_OFS    = 4;
endpackage

// File: rtl/ucr_slot_track.sv
module ucr_slot_track #(
   parameter int unsigned RING_DEPTH = 8,
   localparam int unsigned SLOT_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [15:0]       used_cnt,
   output logic [SLOT_W-1:0] slot
);
   localparam bit IS_POW2 = (RING_DEPTH & (RING_DEPTH - 1)) == 0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         used_cnt <= '0;
      else if (advance)
         used_cnt <= used_cnt + 16'd1;
   end

   generate
      if (IS_POW2) begin : g_mask
         assign slot = used_cnt[SLOT_W-1:0];
      end else begin : g_wrap
         logic [SLOT_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q <= '0;
            else if (advance)
               slot_q <= (slot_q == SLOT_W'(RING_DEPTH - 1)) ? '0 : slot_q + 1'b1;
         end
         assign slot = slot_q;
      end
   endgenerate
endmodule

// File: rtl/ucr_addr_gen.sv
module ucr_addr_gen
   import ucr_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned SLOT_W = 3
) (
   input  ucr_st_e           st,
   input  logic [AW-1:0]     used_base,
   input  logic [AW-1:0]     avail_base,
   input  logic [SLOT_W-1:0] slot,
   output logic [AW-1:0]     addr
);
   logic [AW-1:0] elem_addr;

   assign elem_addr = used_base + AW'(HDR_BYTES) + (AW'(slot) << ELEM_SHIFT);

   always_comb begin
      unique case (st)
         ST_ELEM_ID:  addr = elem_addr;
         ST_ELEM_LEN: addr = elem_addr + AW'(LEN_OFS);
         ST_IDX_WR:   addr = used_base + AW'(IDX_OFS);
         ST_AFLG_RD:  addr = avail_base;
         default:     addr = used_base;
      endcase
   end
endmodule

// File: rtl/ucr_irq_gate.sv
module ucr_irq_gate #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval,
   input  logic             avail_noint,
   input  logic             feat_empty,
   input  logic             is_empty,
   output logic             irq,
   output logic [CNT_W-1:0] skipped
);
   logic raise;

   assign raise = !avail_noint || (feat_empty && is_empty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         skipped <= '0;
      end else begin
         irq <= eval && raise;
         if (eval && !raise)
            skipped <= skipped + 1'b1;
      end
   end
endmodule

// File: rtl/used_ring_completer.sv
module used_ring_completer
   import ucr_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned ID_W       = 16,
   parameter int unsigned LEN_W      = 32,
   parameter int unsigned RING_DEPTH = 8,
   parameter int unsigned CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    used_base,
   input  logic [AW-1:0]    avail_base,
   input  logic             feat_notify_empty,
   input  logic             queue_empty,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [1:0]       cmd_op,
   input  logic [ID_W-1:0]  cmd_id,
   input  logic [LEN_W-1:0] cmd_len,
   output logic             cmd_done,
   output logic             mem_valid,
   input  logic             mem_ready,
   output logic             mem_write,
   output logic             mem_wide,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [15:0]      mem_rdata,
   output logic             irq_pulse,
   output logic [CNT_W-1:0] skip_count,
   output logic [15:0]      next_used
);
   localparam int unsigned SLOT_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;

   generate
      if (RING_DEPTH < 2 || RING_DEPTH > 32768) begin : g_bad_depth
         $error("RING_DEPTH must lie in 2..32768");
      end
      if (ID_W < 1 || ID_W > 32) begin : g_bad_id
         $error("ID_W must lie in 1..32");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("LEN_W must lie in 1..32");
      end
      if (AW < 8 || CNT_W < 1) begin : g_bad_misc
         $error("AW must be at least 8 and CNT_W at least 1");
      end
   endgenerate

   ucr_st_e           st;
   ucr_op_e           op_q;
   logic [ID_W-1:0]   id_q;
   logic [LEN_W-1:0]  len_q;
   logic [15:0]       flag_q;
   logic [SLOT_W-1:0] slot;
   logic              accept;
   logic              advance;
   logic              eval;
   logic              finish;

   assign cmd_ready = (st == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign mem_valid = (st != ST_IDLE);
   assign mem_write = (st == ST_ELEM_ID) || (st == ST_ELEM_LEN) ||
                      (st == ST_IDX_WR)  || (st == ST_UFLG_WR);
   assign mem_wide  = (st == ST_ELEM_ID) || (st == ST_ELEM_LEN);
   assign advance   = (st == ST_ELEM_LEN) && mem_ready;
   assign eval      = (st == ST_AFLG_RD) && mem_ready;
   assign finish    = mem_ready && ((st == ST_ELEM_LEN) || (st == ST_AFLG_RD) ||
                                    (st == ST_UFLG_WR));

   always_comb begin
      unique case (st)
         ST_ELEM_ID:  mem_wdata = 32'(id_q);
         ST_ELEM_LEN: mem_wdata = 32'(len_q);
         ST_IDX_WR:   mem_wdata = {16'h0, next_used};
         ST_UFLG_WR:  mem_wdata = {16'h0, flag_q};
         default:     mem_wdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_PUT;
         id_q     <= '0;
         len_q    <= '0;
         flag_q   <= '0;
         cmd_done <= 1'b0;
      end else begin
         cmd_done <= finish;
         unique case (st)
            ST_IDLE: if (accept) begin
               op_q  <= ucr_op_e'(cmd_op);
               id_q  <= cmd_id;
               len_q <= cmd_len;
               unique case (ucr_op_e'(cmd_op))
                  OP_PUT:  st <= ST_ELEM_ID;
                  OP_SYNC: st <= ST_IDX_WR;
                  default: st <= ST_UFLG_RD;
               endcase
            end
            ST_ELEM_ID:  if (mem_ready) st <= ST_ELEM_LEN;
            ST_ELEM_LEN: if (mem_ready) st <= ST_IDLE;
            ST_IDX_WR:   if (mem_ready) st <= ST_AFLG_RD;
            ST_AFLG_RD:  if (mem_ready) st <= ST_IDLE;
            ST_UFLG_RD:  if (mem_ready) begin
               flag_q <= (op_q == OP_NTF_ON) ? (mem_rdata & 16'hFFFE)
                                             : (mem_rdata | 16'h0001);
               st     <= ST_UFLG_WR;
            end
            ST_UFLG_WR:  if (mem_ready) st <= ST_IDLE;
            default:     st <= ST_IDLE;
         endcase
      end
   end

   ucr_slot_track #(.RING_DEPTH(RING_DEPTH)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .used_cnt (next_used),
      .slot     (slot)
   );

   ucr_addr_gen #(.AW(AW), .SLOT_W(SLOT_W)) u_addr (
      .st         (st),
      .used_base  (used_base),
      .avail_base (avail_base),
      .slot       (slot),
      .addr       (mem_addr)
   );

   ucr_irq_gate #(.CNT_W(CNT_W)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .eval        (eval),
      .avail_noint (mem_rdata[0]),
      .feat_empty  (feat_notify_empty),
      .is_empty    (queue_empty),
      .irq         (irq_pulse),
      .skipped     (skip_count)
   );
endmodule

// File: rtl/ucr_checker.sv
module ucr_checker #(
   parameter int unsigned AW    = 32,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_ready,
   input logic             cmd_done,
   input logic             mem_valid,
   input logic             mem_ready,
   input logic             mem_write,
   input logic [AW-1:0]    mem_addr,
   input logic [31:0]      mem_wdata,
   input logic             irq_pulse,
   input logic [CNT_W-1:0] skip_count,
   input logic [15:0]      next_used
);
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                  $stable(mem_wdata) && $stable(mem_write));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !cmd_ready);

   assert_used_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      next_used != $past(next_used) |-> next_used == $past(next_used) + 16'd1);

   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   assert_irq_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> cmd_done);

   assert_skip_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      skip_count != $past(skip_count) |->
         !irq_pulse && skip_count == $past(skip_count) + 1'b1);
endmodule

bind used_ring_completer ucr_checker #(.AW(AW), .CNT_W(CNT_W)) u_ucr_checker (.*);

// File: tb/test_used_ring_completer.sv
module test_used_ring_completer;
   localparam int unsigned AW    = 32;
   localparam int unsigned DEPTH = 6;
   localparam logic [AW-1:0] UBASE = 32'h100;
   localparam logic [AW-1:0] ABASE = 32'h040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        feat_notify_empty = 1'b0;
   logic        queue_empty = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [15:0] cmd_id = '0;
   logic [31:0] cmd_len = '0;
   logic        cmd_done;
   logic        mem_valid, mem_ready, mem_write, mem_wide;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        irq_pulse;
   logic [15:0] skip_count;
   logic [15:0] next_used;

   logic [15:0] mem [0:511];
   int          lat = 0;
   int          wcnt = 0;
   int          irq_cnt = 0;
   int          cycles = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   used_ring_completer #(.AW(AW), .RING_DEPTH(DEPTH)) i_used_ring_completer (
      .clk(clk), .rst_n(rst_n), .used_base(UBASE), .avail_base(ABASE),
      .feat_notify_empty(feat_notify_empty), .queue_empty(queue_empty),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_done(cmd_done),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .irq_pulse(irq_pulse), .skip_count(skip_count),
      .next_used(next_used)
   );

   // memory responder: serves a request after lat wait cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready = 1'b0;
         mem_rdata = '0;
         wcnt = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         mem_rdata = '0;
      end else if (mem_valid) begin
         if (wcnt >= lat) begin
            if (mem_write) begin
               mem[mem_addr[9:1]] = mem_wdata[15:0];
               if (mem_wide) mem[mem_addr[9:1] + 9'd1] = mem_wdata[31:16];
            end else begin
               mem_rdata = mem[mem_addr[9:1]];
            end
            mem_ready = 1'b1;
            wcnt = 0;
         end else begin
            wcnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && irq_pulse) irq_cnt++;
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog: run hung, act=%0d cycles exp=<100000", cycles);
         summary();
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [15:0] id, input logic [31:0] len);
      int t;
      @(negedge clk);
      cmd_op = op; cmd_id = id; cmd_len = len; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 busy after accept", {31'b0, cmd_ready}, 32'd0);
      t = 0;
      while (!cmd_done && t < 200) begin
         @(negedge clk);
         t++;
      end
      check("R9 command completes", {31'b0, cmd_done}, 32'd1);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 16'hFFFF;
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 cmd_ready", {31'b0, cmd_ready}, 32'd1);
      check("R1 next_used", {16'b0, next_used}, 32'd0);
      check("R1 skip_count", {16'b0, skip_count}, 32'd0);
      check("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
      check("R1 irq", {31'b0, irq_pulse}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3: puts wrapping the ring more than twice
      for (int k = 0; k < 14; k++) begin
         logic [15:0] id;
         logic [31:0] len;
         int          a;
         id  = 16'h3000 + 16'(k * 7);
         len = 32'd100 + 32'(k * 13);
         lat = k % 3;
         do_cmd(2'd0, id, len);
         a = (int'(UBASE) + 4 + 8 * (k % DEPTH)) / 2;
         check("R3 next_used step", {16'b0, next_used}, 32'(k + 1));
         check("R2 element id", {mem[a + 1], mem[a]}, {16'h0, id});
         check("R2 element len", {mem[a + 3], mem[a + 2]}, len);
         check("R3 index untouched by put", {16'b0, mem[(UBASE + 2) / 2]}, 32'h0000FFFF);
      end

      // R4..R7: sweep of flag bit, feature and empty
      for (int c = 0; c < 8; c++) begin
         logic aflag, raise;
         int   i0, s0;
         aflag = c[0];
         feat_notify_empty = c[1];
         queue_empty = c[2];
         raise = !aflag || (c[1] && c[2]);
         mem[ABASE / 2] = 16'h5A5A | {15'b0, aflag};
         mem[(UBASE + 2) / 2] = 16'hFFFF;
         i0 = irq_cnt;
         s0 = int'(skip_count);
         lat = c % 3;
         do_cmd(2'd1, 16'h0, 32'h0);
         check("R4 index published", {16'b0, mem[(UBASE + 2) / 2]}, 32'd14);
         if (!aflag)
            check("R5 irq with flag clear", 32'(irq_cnt - i0), 32'd1);
         else
            check("R6 irq on empty override", 32'(irq_cnt - i0), {31'b0, raise});
         check("R7 skip count", 32'(int'(skip_count) - s0), {31'b0, !raise});
      end

      // R3: put after sync leaves published index alone
      do_cmd(2'd0, 16'h0077, 32'd5);
      check("R3 index stale after put", {16'b0, mem[(UBASE + 2) / 2]}, 32'd14);
      check("R3 counter", {16'b0, next_used}, 32'd15);
      do_cmd(2'd1, 16'h0, 32'h0);
      check("R4 index after second sync", {16'b0, mem[(UBASE + 2) / 2]}, 32'd15);

      // R8: notify hint read-modify-write
      mem[UBASE / 2] = 16'hA5A4;
      lat = 2;
      do_cmd(2'd3, 16'h0, 32'h0);
      check("R8 disable sets bit0", {16'b0, mem[UBASE / 2]}, 32'h0000A5A5);
      do_cmd(2'd3, 16'h0, 32'h0);
      check("R8 disable idempotent", {16'b0, mem[UBASE / 2]}, 32'h0000A5A5);
      lat = 0;
      do_cmd(2'd2, 16'h0, 32'h0);
      check("R8 enable clears bit0", {16'b0, mem[UBASE / 2]}, 32'h0000A5A4);
      mem[UBASE / 2] = 16'h7F03;
      do_cmd(2'd2, 16'h0, 32'h0);
      check("R8 enable keeps upper bits", {16'b0, mem[UBASE / 2]}, 32'h00007F02);
      check("R8 counter untouched", {16'b0, next_used}, 32'd15);

      summary();
   end
endmodule